// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one 32-pin general-purpose I/O port behind a small word-addressed register interface. Software sets each pin's direction and its output level. Output bits can be written as a whole word, or changed one at a time through write-one set and write-one clear locations that leave every other bit alone. The input pins pass through a two-flop synchronizer, and software can read their synchronized value. Two storage-only registers hold pull configuration and drive it straight to the pad ring.

Each pin has its own event detector. It can sense a rising edge, a falling edge, both edges, an active-high level or an active-low level. An enabled event sets a sticky status bit, and software removes that bit by writing a one to it. A per-pin mask selects which status bits reach the single combined interrupt line.

Register word addresses: output 0x0, input 0x1, direction 0x2, set 0x4, clear 0x5, pull enable 0x6, pull type 0x7, interrupt enable 0x8, status 0x9, mask 0xB, status clear 0xC, trigger type 0xD, both-edge 0xE, polarity 0xF. Unlisted addresses read as zero.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, pinOut, pinDir, pullEn, pullType and irqOut are 0. The enable (0x8), mask (0xB) and status (0x9) registers read 0.
- R2: A write to 0x0 loads the output register, which drives pinOut. A write to 0x2 loads the direction register, which drives pinDir (1 = output). Both read back at their addresses.
- R3: A write to 0x4 sets every output bit where the write data has a 1. A write to 0x5 clears every such bit. All other output bits keep their value.
- R4: Read data appears on rdData one cycle after the read request. Reads of 0x4, 0x5 and 0xC return 0. A read of 0x1 returns pinIn after it passes the two-flop synchronizer.
- R5: With trigger type 0 (edge), polarity 0 and both-edge 0, a rising pin sets its status bit and a falling pin does not.
- R6: With trigger type 0 and polarity 1, a falling pin sets its status bit and a rising pin does not.
- R7: In edge mode, a both-edge bit of 1 makes either transition set the status bit, whatever the polarity bit holds.
- R8: With trigger type 1 (level), polarity 0 sets status while the pin is high, and polarity 1 sets it while the pin is low. A status-clear write made while the level is still active leaves the bit reading 1.
- R9: A pin whose interrupt enable bit is 0 never sets its status bit.
- R10: Writing a 1 to 0xC clears that pin's status bit. If a new enabled event on the same pin falls in the same cycle as the clear, the bit stays 1.
- R11: irqOut is 1 exactly when some status bit is 1 and its mask bit is 0. Masking a pin does not stop its status bit from being set.
- R12: Pull enable (0x6) and pull type (0x7) are plain storage. They read back and drive the pullEn and pullType ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Register access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 4 | Word address |
| reqWdata | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| pinIn | input | 32 | Asynchronous pin inputs |
| pinOut | output | 32 | Output data to pads |
| pinDir | output | 32 | Per-pin direction, 1 = output |
| pullEn | output | 32 | Pull enable storage |
| pullType | output | 32 | Pull type storage |
| irqOut | output | 1 | Combined unmasked interrupt |

## Verification
The hard collision is a status-clear write landing in the same cycle as a fresh detected event on the same pin. The bench latches a status bit on a both-edge pin and then toggles that pin. It times the clear write to commit on the exact edge where the synchronized transition registers as an event, counting two synchronizer flops and then the status register. The status bit must read 1 afterwards. A second clear, made with the pin quiet, must then drop the bit. This shows that the earlier result came from the collision and not from a clear that had no effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_OUT  = 4'h0;
  localparam logic [ADDR_W-1:0] A_IN   = 4'h1;
  localparam logic [ADDR_W-1:0] A_DIR  = 4'h2;
  localparam logic [ADDR_W-1:0] A_SET  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'h5;
  localparam logic [ADDR_W-1:0] A_PEN  = 4'h6;
  localparam logic [ADDR_W-1:0] A_PTYP = 4'h7;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'h8;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h9;
  localparam logic [ADDR_W-1:0] A_MASK = 4'hB;
  localparam logic [ADDR_W-1:0] A_ICLR = 4'hC;
  localparam logic [ADDR_W-1:0] A_TRIG = 4'hD;
  localparam logic [ADDR_W-1:0] A_BOTH = 4'hE;
  localparam logic [ADDR_W-1:0] A_POL  = 4'hF;

  typedef struct packed {
    logic outWr;
    logic dirWr;
    logic setWr;
    logic clrWr;
    logic penWr;
    logic ptypWr;
    logic ienWr;
    logic maskWr;
    logic iclrWr;
    logic trigWr;
    logic bothWr;
    logic polWr;
    logic rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } strobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           strb
);
  logic wrEn;
  assign wrEn = reqValid && reqWrite;

  always_comb begin
    strb        = '0;
    strb.rdEn   = reqValid && !reqWrite;
    strb.rdAddr = reqAddr;
    if (wrEn) begin
      case (reqAddr)
        A_OUT:  strb.outWr  = 1'b1;
        A_DIR:  strb.dirWr  = 1'b1;
        A_SET:  strb.setWr  = 1'b1;
        A_CLR:  strb.clrWr  = 1'b1;
        A_PEN:  strb.penWr  = 1'b1;
        A_PTYP: strb.ptypWr = 1'b1;
        A_IEN:  strb.ienWr  = 1'b1;
        A_MASK: strb.maskWr = 1'b1;
        A_ICLR: strb.iclrWr = 1'b1;
        A_TRIG: strb.trigWr = 1'b1;
        A_BOTH: strb.bothWr = 1'b1;
        A_POL:  strb.polWr  = 1'b1;
        default: ;
      endcase
    end
  end

  // At most one register write strobe per request (supports R2, R3, R10)
  p_onehot_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.outWr, strb.dirWr, strb.setWr, strb.clrWr, strb.penWr,
              strb.ptypWr, strb.ienWr, strb.maskWr, strb.iclrWr,
              strb.trigWr, strb.bothWr, strb.polWr}));

  // A read never raises a write strobe
  p_rd_no_wr_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |-> !(strb.setWr || strb.clrWr || strb.iclrWr || strb.outWr));
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinDir,
  output logic [WIDTH-1:0] pullEn,
  output logic [WIDTH-1:0] pullType,
  output logic             irqOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] outQ, dirQ, penQ, ptypQ;
  logic [WIDTH-1:0] ienQ, maskQ, statQ, trigQ, bothQ, polQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] prevQ, syncd;
  logic [WIDTH-1:0] hit, event_, rdNext;

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0; dirQ  <= '0; penQ  <= '0; ptypQ <= '0;
      ienQ  <= '0; maskQ <= '0; trigQ <= '0; bothQ <= '0; polQ <= '0;
    end else begin
      if (strb.outWr)       outQ <= wdata;
      else if (strb.setWr)  outQ <= outQ | wdata;
      else if (strb.clrWr)  outQ <= outQ & ~wdata;
      if (strb.dirWr)  dirQ  <= wdata;
      if (strb.penWr)  penQ  <= wdata;
      if (strb.ptypWr) ptypQ <= wdata;
      if (strb.ienWr)  ienQ  <= wdata;
      if (strb.maskWr) maskQ <= wdata;
      if (strb.trigWr) trigQ <= wdata;
      if (strb.bothWr) bothQ <= wdata;
      if (strb.polWr)  polQ  <= wdata;
    end
  end

  // ---------------- input synchronizer ----------------
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncd = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncd;
  end

  // ---------------- per-pin event detection ----------------
  genvar p;
  generate
    for (p = 0; p < WIDTH; p++) begin : g_det
      logic rise, fall, edgeHit, levelHit;
      always_comb begin
        rise     = syncd[p] & ~prevQ[p];
        fall     = ~syncd[p] & prevQ[p];
        edgeHit  = bothQ[p] ? (rise | fall) : (polQ[p] ? fall : rise);
        levelHit = polQ[p] ? ~syncd[p] : syncd[p];
        hit[p]   = trigQ[p] ? levelHit : edgeHit;
      end
    end
  endgenerate

  assign event_ = hit & ienQ;

  // Status: a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else if (strb.iclrWr) statQ <= (statQ & ~wdata) | event_;
    else statQ <= statQ | event_;
  end

  // ---------------- read path ----------------
  always_comb begin
    case (strb.rdAddr)
      A_OUT:  rdNext = outQ;
      A_IN:   rdNext = syncd;
      A_DIR:  rdNext = dirQ;
      A_PEN:  rdNext = penQ;
      A_PTYP: rdNext = ptypQ;
      A_IEN:  rdNext = ienQ;
      A_STAT: rdNext = statQ;
      A_MASK: rdNext = maskQ;
      A_TRIG: rdNext = trigQ;
      A_BOTH: rdNext = bothQ;
      A_POL:  rdNext = polQ;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  assign pinOut   = outQ;
  assign pinDir   = dirQ;
  assign pullEn   = penQ;
  assign pullType = ptypQ;
  assign irqOut   = |(statQ & ~maskQ);

  // ---------------- assertions ----------------
  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> ((outQ & $past(wdata)) == $past(wdata)));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |=> ((outQ & $past(wdata)) == '0));

  p_set_keeps_others_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> ((outQ & ~$past(wdata)) == ($past(outQ) & ~$past(wdata))));

  p_wo_reads_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && (strb.rdAddr == A_SET || strb.rdAddr == A_CLR ||
                   strb.rdAddr == A_ICLR)) |=> (rdData == '0));

  p_stat_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((statQ & ~$past(statQ) & ~$past(ienQ)) == '0));

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.iclrWr |=> ((statQ & $past(wdata) & ~$past(event_)) == '0));

  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (($past(statQ) != statQ) || ($past(maskQ) != maskQ)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WIDTH-1:0]  reqWdata,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinDir,
  output logic [WIDTH-1:0]  pullEn,
  output logic [WIDTH-1:0]  pullType,
  output logic              irqOut
);
  strobe_t strb;

  gpio_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .strb     (strb)
  );

  gpio_irq_dp #(.WIDTH(WIDTH), .SYNC_STAGES(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (reqWdata),
    .pinIn    (pinIn),
    .rdData   (rdData),
    .pinOut   (pinOut),
    .pinDir   (pinDir),
    .pullEn   (pullEn),
    .pullType (pullType),
    .irqOut   (irqOut)
  );

  // Reset leaves the port quiet (R1)
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!irqOut && pinOut == '0 && pinDir == '0));
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0, reqWrite = 0;
  logic [3:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0, pinIn = '0;
  logic [31:0] rdData, pinOut, pinDir, pullEn, pullType;
  logic        irqOut;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinDir(pinDir), .pullEn(pullEn), .pullType(pullType),
    .irqOut(irqOut)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // Register path vectors (R2, R3, R4, R12)
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h0, 32'h0000_00FF, 32'h0},
    '{1'b0, 4'h0, 32'h0, 32'h0000_00FF},
    '{1'b1, 4'h4, 32'hF000_0000, 32'h0},
    '{1'b0, 4'h0, 32'h0, 32'hF000_00FF},
    '{1'b1, 4'h5, 32'h0000_000F, 32'h0},
    '{1'b0, 4'h0, 32'h0, 32'hF000_00F0},
    '{1'b0, 4'h4, 32'h0, 32'h0},
    '{1'b0, 4'h5, 32'h0, 32'h0},
    '{1'b1, 4'h2, 32'hA5A5_A5A5, 32'h0},
    '{1'b0, 4'h2, 32'h0, 32'hA5A5_A5A5},
    '{1'b1, 4'h6, 32'h1234_5678, 32'h0},
    '{1'b0, 4'h6, 32'h0, 32'h1234_5678},
    '{1'b1, 4'h7, 32'h0F0F_0000, 32'h0},
    '{1'b0, 4'h7, 32'h0, 32'h0F0F_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(posedge clk);
    #1 d = rdData;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic setPins(input logic [31:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 rstN = 1;

    // R1 reset state
    #1;
    check("R1 pinOut", pinOut, 0);
    check("R1 pinDir", pinDir, 0);
    check("R1 pullEn", pullEn, 0);
    check("R1 pullType", pullType, 0);
    check("R1 irqOut", {31'b0, irqOut}, 0);
    rd(4'h8, d); check("R1 enable", d, 0);
    rd(4'h B, d); check("R1 mask", d, 0);
    rd(4'h9, d); check("R1 status", d, 0);

    // Vector table: R2 R3 R4 R12
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, d);
        check($sformatf("R2/R3/R4/R12 vector %0d", i), d, VECS[i].exp);
      end
    end
    check("R3 pinOut port", pinOut, 32'hF000_00F0);
    check("R2 pinDir port", pinDir, 32'hA5A5_A5A5);
    check("R12 pullEn port", pullEn, 32'h1234_5678);
    check("R12 pullType port", pullType, 32'h0F0F_0000);
    rd(4'hC, d); check("R4 clear addr reads 0", d, 0);

    // R4 synchronized input
    setPins(32'hDEAD_BEEF);
    rd(4'h1, d); check("R4 input read", d, 32'hDEAD_BEEF);
    setPins(32'h0);
    rd(4'h1, d); check("R4 input read zero", d, 0);

    // Modes: bit0 rise, bit1 fall, bit2 both, bit3 level-high, bit4 level-low
    wr(4'hD, 32'h0000_0018);
    wr(4'hF, 32'h0000_0016);
    wr(4'hE, 32'h0000_0004);

    // R5 rising edge
    wr(4'h8, 32'h1);
    setPins(32'h1);
    rd(4'h9, d); check("R5 rise sets", d, 32'h1);
    check("R11 irq on", {31'b0, irqOut}, 1);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h9, d); check("R10 clear", d, 0);
    check("R11 irq off", {31'b0, irqOut}, 0);
    setPins(32'h0);
    rd(4'h9, d); check("R5 fall ignored", d, 0);

    // R6 falling edge
    wr(4'h8, 32'h2);
    setPins(32'h2);
    rd(4'h9, d); check("R6 rise ignored", d, 0);
    setPins(32'h0);
    rd(4'h9, d); check("R6 fall sets", d, 32'h2);
    wr(4'hC, 32'h2);

    // R7 both edges
    wr(4'h8, 32'h4);
    setPins(32'h4);
    rd(4'h9, d); check("R7 rise sets", d, 32'h4);
    wr(4'hC, 32'h4);
    rd(4'h9, d); check("R7 cleared", d, 0);
    setPins(32'h0);
    rd(4'h9, d); check("R7 fall sets", d, 32'h4);

    // R10 clear colliding with new event on bit2 (status already 1)
    @(negedge clk);
    pinIn = 32'h4;
    @(negedge clk);
    wr(4'hC, 32'h4);
    rd(4'h9, d); check("R10 event beats clear", d, 32'h4);
    wr(4'hC, 32'h4);
    rd(4'h9, d); check("R10 quiet clear", d, 0);
    setPins(32'h0);
    wr(4'hC, 32'hFFFF_FFFF);

    // R8 level high
    wr(4'h8, 32'h8);
    rd(4'h9, d); check("R8 high idle", d, 0);
    setPins(32'h8);
    rd(4'h9, d); check("R8 high sets", d, 32'h8);
    wr(4'hC, 32'h8);
    rd(4'h9, d); check("R8 clear while active", d, 32'h8);
    setPins(32'h0);
    wr(4'hC, 32'h8);
    rd(4'h9, d); check("R8 clear after release", d, 0);

    // R8 level low (pin already low)
    wr(4'h8, 32'h10);
    repeat (2) @(negedge clk);
    rd(4'h9, d); check("R8 low sets", d, 32'h10);

    // R11 mask
    wr(4'hB, 32'h10);
    #1 check("R11 masked irq", {31'b0, irqOut}, 0);
    rd(4'h9, d); check("R11 status kept", d, 32'h10);
    wr(4'hB, 32'h0);
    #1 check("R11 unmasked irq", {31'b0, irqOut}, 1);
    setPins(32'h10);
    wr(4'hC, 32'hFFFF_FFFF);

    // R9 disabled pin
    wr(4'h8, 32'h0);
    setPins(32'h1);
    setPins(32'h0);
    setPins(32'h8);
    rd(4'h9, d); check("R9 disabled no status", d, 0);
    check("R9 irq low", {31'b0, irqOut}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule